// File: doc/BRIEF.md
# Serial Character Receiver with Parity Checking and Sticky Status

This block recovers characters from an asynchronous serial line. The line passes through a two-flop synchronizer. It is then sampled on an enable tick that runs at sixteen times the bit rate. A character is one low start bit, eight data bits with the least significant bit first, an optional parity bit and one stop bit. The start bit is confirmed at its mid-point, and every later bit is sampled at its centre. A start bit that is high again by mid-bit is treated as a glitch and dropped.

Each completed character goes into a holding register, and the ready flag rises. For the outgoing data, the ready flag acts as the valid signal and the read strobe acts as the acceptance. There is no back-pressure toward the line. A character that arrives while the previous one is unread overwrites it and raises a sticky overrun flag. Overrun and parity-error flags stay set until a reset-status command clears them; reading the data does not clear them. An interrupt output combines the three flags through a mask.

Top module: `uart_rx_core`

## Requirements
- R1: A frame is a low start bit followed by eight data bits, least significant first. Each bit lasts sixteen sample ticks, and each bit is sampled at its centre. The data appears on `hold_data` when the character completes.
- R2: A low level on the line that has returned high eight ticks after it was detected is dropped as a glitch. It loads no character, and the receiver is ready for the next frame.
- R3: The `par_mode` codes are: 0 = even, 1 = odd, 2 = space, 3 = mark, and 4 to 7 = no parity. Even parity expects the XOR of the data bits. Odd parity expects its inverse. Space always expects 0 and mark always expects 1.
- R4: A parity bit that differs from the expected value sets `flag_parity`. In the no-parity codes no parity bit is sampled, so the stop bit directly follows data bit 7, and `flag_parity` is never set.
- R5: When a character completes, it is written to `hold_data` and `flag_ready` rises, even if the previous character was never read.
- R6: A character that completes while `flag_ready` is already set raises `flag_overrun`.
- R7: A `hold_rd` pulse clears `flag_ready`. If `hold_rd` and a character load fall in the same cycle, the load wins and `flag_ready` stays set.
- R8: `flag_overrun` and `flag_parity` are sticky. `hold_rd` does not clear them; `rst_status` clears both. If a new error and `rst_status` fall in the same cycle, the error wins.
- R9: `irq` is high when any flag is set and its mask bit is set. The mask bits are: bit 0 = ready, bit 1 = overrun, bit 2 = parity error.
- R10: After reset all flags are low, `hold_data` is zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_tick | input | 1 | Enable at sixteen times the bit rate |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| par_mode | input | 3 | Parity mode code (R3) |
| irq_mask | input | 3 | Interrupt enables: ready, overrun, parity error |
| hold_rd | input | 1 | Read strobe for the holding register |
| rst_status | input | 1 | Clears the overrun and parity-error flags |
| hold_data | output | 8 | Receive holding register |
| flag_ready | output | 1 | Unread character present (valid) |
| flag_overrun | output | 1 | Sticky overrun flag |
| flag_parity | output | 1 | Sticky parity-error flag |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench sends characters with correct and corrupted parity in every parity mode, including an unused code that must act as no-parity. A receiver that sampled a phantom parity bit would misalign the next frame, and one that computed parity wrongly would flag good characters. It sends two characters without a read in between and checks that the second overwrites the first and raises overrun. It then checks that a read clears only the ready flag and that only the reset-status command clears the error flags. It holds the read strobe high through a load to catch a design that lets the read beat the load. It also sends a short low glitch that a careless start detector would accept as a character.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int NFLAG = 3;

  typedef enum logic [2:0] {
    PM_EVEN  = 3'd0,
    PM_ODD   = 3'd1,
    PM_SPACE = 3'd2,
    PM_MARK  = 3'd3,
    PM_NONE  = 3'd4
  } par_mode_e;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP
  } rx_state_e;

  function automatic logic par_enabled(input logic [2:0] mode);
    return (mode < 3'd4);
  endfunction

  function automatic logic par_expect(input logic [2:0] mode, input logic [7:0] d);
    case (mode)
      PM_EVEN:  return ^d;
      PM_ODD:   return ~^d;
      PM_SPACE: return 1'b0;
      PM_MARK:  return 1'b1;
      default:  return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '1;
    else        q <= {q[STAGES-2:0], din};
  end

  assign dout = q[STAGES-1];
endmodule

// File: rtl/uart_rx_bitrec.sv
module uart_rx_bitrec
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line,
  input  logic [2:0]        par_mode,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              par_bad
);
  localparam int CW  = $clog2(OSR);
  localparam int BW  = $clog2(DATA_W);
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);
  localparam logic [BW-1:0] LASTBIT = BW'(DATA_W - 1);

  rx_state_e         state;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bidx;
  logic [DATA_W-1:0] shreg;
  logic              pbad_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      bidx   <= '0;
      shreg  <= '0;
      pbad_r <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (state)
          S_IDLE: begin
            cnt <= '0;
            if (!line) begin
              state  <= S_START;
              pbad_r <= 1'b0;
            end
          end
          S_START: begin
            if (cnt == MID) begin
              cnt   <= '0;
              bidx  <= '0;
              state <= line ? S_IDLE : S_DATA;
            end else cnt <= cnt + 1'b1;
          end
          S_DATA: begin
            if (cnt == LAST) begin
              cnt   <= '0;
              shreg <= {line, shreg[DATA_W-1:1]};
              if (bidx == LASTBIT)
                state <= par_enabled(par_mode) ? S_PAR : S_STOP;
              else
                bidx <= bidx + 1'b1;
            end else cnt <= cnt + 1'b1;
          end
          S_PAR: begin
            if (cnt == LAST) begin
              cnt    <= '0;
              pbad_r <= (line != par_expect(par_mode, shreg));
              state  <= S_STOP;
            end else cnt <= cnt + 1'b1;
          end
          S_STOP: begin
            if (cnt == LAST) begin
              cnt   <= '0;
              done  <= 1'b1;
              state <= S_IDLE;
            end else cnt <= cnt + 1'b1;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assign data    = shreg;
  assign par_bad = pbad_r;
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              load_perr,
  input  logic              rd,
  input  logic              clr,
  output logic [DATA_W-1:0] hold,
  output logic              rdy,
  output logic              ovr,
  output logic              perr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold <= '0;
      rdy  <= 1'b0;
      ovr  <= 1'b0;
      perr <= 1'b0;
    end else begin
      if (load)      hold <= load_data;

      if (load)      rdy <= 1'b1;
      else if (rd)   rdy <= 1'b0;

      if (load && rdy) ovr <= 1'b1;
      else if (clr)    ovr <= 1'b0;

      if (load && load_perr) perr <= 1'b1;
      else if (clr)          perr <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int OSR       = 16,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_tick,
  input  logic              rx_line,
  input  logic [2:0]        par_mode,
  input  logic [NFLAG-1:0]  irq_mask,
  input  logic              hold_rd,
  input  logic              rst_status,
  output logic [DATA_W-1:0] hold_data,
  output logic              flag_ready,
  output logic              flag_overrun,
  output logic              flag_parity,
  output logic              irq
);
  logic              line_s;
  logic              char_done;
  logic [DATA_W-1:0] char_data;
  logic              char_pbad;

  uart_rx_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(line_s)
  );

  uart_rx_bitrec #(.DATA_W(DATA_W), .OSR(OSR)) u_rec (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick), .line(line_s),
    .par_mode(par_mode), .done(char_done), .data(char_data), .par_bad(char_pbad)
  );

  uart_rx_status #(.DATA_W(DATA_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .load(char_done), .load_data(char_data),
    .load_perr(char_pbad), .rd(hold_rd), .clr(rst_status),
    .hold(hold_data), .rdy(flag_ready), .ovr(flag_overrun), .perr(flag_parity)
  );

  assign irq = |({flag_parity, flag_overrun, flag_ready} & irq_mask);
endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       load,
  input logic       hold_rd,
  input logic       rst_status,
  input logic [2:0] par_mode,
  input logic [2:0] irq_mask,
  input logic       flag_ready,
  input logic       flag_overrun,
  input logic       flag_parity,
  input logic       irq
);
  assert_load_sets_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> flag_ready);

  assert_overrun_on_unread_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && flag_ready) |=> flag_overrun);

  assert_read_clears_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_rd && !load) |=> !flag_ready);

  assert_clear_errors_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_status && !load) |=> (!flag_overrun && !flag_parity));

  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_overrun && !rst_status) |=> flag_overrun);

  assert_parity_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_parity && !rst_status) |=> flag_parity);

  assert_no_parity_err_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (par_mode[2] && !flag_parity) |=> !flag_parity);

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask == 3'b000) |-> !irq);
endmodule

bind uart_rx_core uart_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .load(char_done), .hold_rd(hold_rd),
  .rst_status(rst_status), .par_mode(par_mode), .irq_mask(irq_mask),
  .flag_ready(flag_ready), .flag_overrun(flag_overrun),
  .flag_parity(flag_parity), .irq(irq)
);

// File: tb/tb_uart_rx_core.sv
module tb_uart_rx_core;
  localparam int CLK_PERIOD = 10;

  typedef struct packed { logic [7:0] d; logic pe; } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic [2:0] par_mode = 3'd0;
  logic [2:0] irq_mask = 3'd0;
  logic       drv_rd = 1'b0, mon_rd = 1'b0, mon_clr = 1'b0, drv_clr = 1'b0;
  logic       hold_rd, rst_status;
  logic [7:0] hold_data;
  logic       flag_ready, flag_overrun, flag_parity, irq;

  logic mon_en = 1'b0;
  logic watch = 1'b0;
  logic seen  = 1'b0;
  int   n_chk = 0, n_fail = 0;
  exp_t q[$];

  assign hold_rd    = drv_rd | mon_rd;
  assign rst_status = drv_clr | mon_clr;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_core dut (
    .clk(clk), .rst_n(rst_n), .sample_tick(1'b1), .rx_line(rx_line),
    .par_mode(par_mode), .irq_mask(irq_mask), .hold_rd(hold_rd),
    .rst_status(rst_status), .hold_data(hold_data), .flag_ready(flag_ready),
    .flag_overrun(flag_overrun), .flag_parity(flag_parity), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bit_out(input logic b);
    @(negedge clk) rx_line = b;
    repeat (15) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic [2:0] mode,
                            input bit flip, input bit push);
    logic p;
    exp_t e;
    par_mode = mode;
    case (mode)
      3'd0: p = ^d;
      3'd1: p = ~^d;
      3'd2: p = 1'b0;
      3'd3: p = 1'b1;
      default: p = 1'b0;
    endcase
    e.d = d;
    e.pe = flip && (mode < 3'd4);
    if (push) q.push_back(e);
    bit_out(1'b0);
    for (int i = 0; i < 8; i++) bit_out(d[i]);
    if (mode < 3'd4) bit_out(p ^ flip);
    bit_out(1'b1);
    repeat (20) @(negedge clk);
  endtask

  // Monitor: pops expected characters as the ready flag rises
  initial begin
    forever begin
      @(negedge clk);
      if (mon_en && flag_ready) begin
        if (q.size() == 0) chk(1'b0, "R5 unexpected character", 32'(hold_data), 32'hFFFF);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(hold_data == e.d, "R1 data", 32'(hold_data), 32'(e.d));
          chk(flag_parity == e.pe, "R4 parity flag", 32'(flag_parity), 32'(e.pe));
        end
        mon_rd = 1'b1; mon_clr = 1'b1;
        @(negedge clk);
        mon_rd = 1'b0; mon_clr = 1'b0;
      end
    end
  end

  always @(negedge clk) if (watch && flag_ready) seen = 1'b1;

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (10) @(negedge clk);
    // R10 reset state
    chk(flag_ready == 1'b0, "R10 ready", 32'(flag_ready), 0);
    chk(flag_overrun == 1'b0, "R10 overrun", 32'(flag_overrun), 0);
    chk(flag_parity == 1'b0, "R10 parity", 32'(flag_parity), 0);
    chk(hold_data == 8'h00, "R10 data", 32'(hold_data), 0);
    chk(irq == 1'b0, "R10 irq", 32'(irq), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    mon_en = 1'b1;

    // R1 R3 R4: good parity in all modes
    send_frame(8'h41, 3'd0, 0, 1);
    send_frame(8'h56, 3'd1, 0, 1);
    send_frame(8'h52, 3'd2, 0, 1);
    send_frame(8'h52, 3'd3, 0, 1);
    send_frame(8'hC3, 3'd4, 0, 1);
    send_frame(8'h3C, 3'd6, 0, 1);   // unused code acts as no parity (R3)
    send_frame(8'h00, 3'd1, 0, 1);
    send_frame(8'hFF, 3'd0, 0, 1);
    // R4: corrupted parity bits
    send_frame(8'h41, 3'd0, 1, 1);
    send_frame(8'h56, 3'd1, 1, 1);
    send_frame(8'h11, 3'd2, 1, 1);
    send_frame(8'h22, 3'd3, 1, 1);

    // R2: glitch rejection
    @(negedge clk) rx_line = 1'b0;
    repeat (3) @(negedge clk);
    rx_line = 1'b1;
    repeat (40) @(negedge clk);
    chk(flag_ready == 1'b0, "R2 glitch ignored", 32'(flag_ready), 0);
    send_frame(8'hA5, 3'd0, 0, 1);
    chk(q.size() == 0, "R1 all characters received", 32'(q.size()), 0);

    // R5 R6: overrun with overwrite
    mon_en = 1'b0;
    irq_mask = 3'b000;
    send_frame(8'h11, 3'd0, 0, 0);
    send_frame(8'h22, 3'd0, 1, 0);
    chk(flag_ready == 1'b1, "R5 ready", 32'(flag_ready), 1);
    chk(hold_data == 8'h22, "R5 overwrite", 32'(hold_data), 32'h22);
    chk(flag_overrun == 1'b1, "R6 overrun", 32'(flag_overrun), 1);
    chk(flag_parity == 1'b1, "R4 parity set", 32'(flag_parity), 1);
    chk(irq == 1'b0, "R9 masked", 32'(irq), 0);
    irq_mask = 3'b010; @(negedge clk);
    chk(irq == 1'b1, "R9 overrun irq", 32'(irq), 1);
    irq_mask = 3'b001; @(negedge clk);
    chk(irq == 1'b1, "R9 ready irq", 32'(irq), 1);

    // R7 R8: read clears ready only
    drv_rd = 1'b1; @(negedge clk); drv_rd = 1'b0;
    chk(flag_ready == 1'b0, "R7 read clears ready", 32'(flag_ready), 0);
    chk(flag_overrun == 1'b1, "R8 overrun kept on read", 32'(flag_overrun), 1);
    chk(flag_parity == 1'b1, "R8 parity kept on read", 32'(flag_parity), 1);
    chk(irq == 1'b0, "R9 ready irq drops", 32'(irq), 0);
    irq_mask = 3'b100; @(negedge clk);
    chk(irq == 1'b1, "R9 parity irq", 32'(irq), 1);
    drv_clr = 1'b1; @(negedge clk); drv_clr = 1'b0;
    chk(flag_overrun == 1'b0, "R8 clear overrun", 32'(flag_overrun), 0);
    chk(flag_parity == 1'b0, "R8 clear parity", 32'(flag_parity), 0);
    chk(irq == 1'b0, "R9 irq after clear", 32'(irq), 0);

    // R7: load beats a simultaneous read
    seen = 1'b0; watch = 1'b1; drv_rd = 1'b1;
    send_frame(8'h33, 3'd0, 0, 0);
    drv_rd = 1'b0; watch = 1'b0;
    chk(seen == 1'b1, "R7 load wins over read", 32'(seen), 1);
    chk(hold_data == 8'h33, "R5 data loaded", 32'(hold_data), 32'h33);
    chk(flag_overrun == 1'b0, "R6 no overrun", 32'(flag_overrun), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule